// File: doc/BRIEF.md
# Multi-Width Bus Byte-Lane Sequencer

This block sits between an internal load/store or fetch unit and a multiplexed external address/data bus. It takes one access request at a time: a start address, a byte count, write or read, data or instruction, and the width of the target memory region (8, 16 or 32 bits). It turns that request into a series of bus transactions. Each transaction has a single address-phase cycle followed by one to four data-phase cycles. There are no wait states.

A request is cut at the natural boundaries of the region width. A leading or trailing fragment that does not fill a bus word goes out as its own single-beat transaction. Runs of whole bus words go out as bursts of up to four beats, and a burst never crosses a 16-byte aligned block. Because of this cutting, the four active-low byte-lane outputs are fixed for the whole of a transaction. On narrow regions some of those lane outputs are reused for the low address bits.

Between transactions the block can hand the bus to another master in response to a hold request. While it holds the bus off, the width attribute lines are released.

Top module: `bus_lane_seq`

## Requirements
- R1: After reset the block is idle. `req_ready`=1, `lane_n`=4'b1111, `hold_ack`=0, `addr_phase`=`data_phase`=0, `width_oe`=1 and `width_o`=2'b10.
- R2: On a 32-bit region (`req_width`=2'b10), `lane_n[i]` is 0 exactly when byte i of the addressed 32-bit word (bits 8i+7:8i) is part of the transaction.
- R3: On a 16-bit region (`req_width`=2'b01), `lane_n[3]` is the active-low high-byte enable and `lane_n[0]` the active-low low-byte enable of the halfword. `lane_n[1]` carries address bit 1 of the transaction start address, and `lane_n[2]` is 1.
- R4: On an 8-bit region (`req_width`=2'b00), `lane_n[3:2]`=2'b11, `lane_n[1]` carries address bit 1 and `lane_n[0]` carries address bit 0 of the transaction start address.
- R5: `width_o` shows 2'b00, 2'b01 or 2'b10 for the active region width. It shows 2'b11 while the block is idle and `cpu_halted`=1.
- R6: Let W be the region width in bytes. If the current address is not W-aligned, or fewer than W bytes remain, one single-beat transaction covers the bytes up to the end of that bus word. Otherwise a burst of k beats moves k*W bytes, where k is the smallest of: remaining whole words, words left before the next 16-byte boundary, and 4. Pieces are issued in ascending address order. A request with a byte count of zero produces no transaction.
- R7: The first address phase comes in the cycle after the request is accepted. Every address phase is followed at once by its data phases. `burst_last` marks the final one. Without a hold, the next piece's address phase follows `burst_last` directly.
- R8: `lane_n`, `dir_o` and `dc_o` are constant from the address phase through the final data phase of a transaction. `bus_addr` shows address bits 31:2 of the transaction start during its address phase.
- R9: `dir_o` is 1 for a write and 0 for a read. `dc_o` is 1 for a data access and 0 for an instruction fetch.
- R10: The bus is handed over only from idle or right after a final data phase. During hand-over, `hold_ack`=1, `width_oe`=0, `lane_n`=4'b1111 and no phase is active. The remaining pieces resume with an address phase in the cycle after `hold_req` is seen low.
- R11: `req_ready` is 0 while a request is in progress, while the bus is handed over, and whenever `hold_req` is 1. A request presented during hand-over is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Byte start address |
| req_nbytes | input | 5 | Byte count, 0 to 16 |
| req_width | input | 2 | Region width code |
| req_write | input | 1 | 1 = write |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| cpu_halted | input | 1 | Core is halted |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus handed over |
| addr_phase | output | 1 | Address phase cycle |
| data_phase | output | 1 | Data phase cycle |
| burst_last | output | 1 | Final data phase of the transaction |
| bus_addr | output | 30 | Address bits 31:2 during the address phase |
| lane_n | output | 4 | Byte-lane / low-address outputs |
| width_o | output | 2 | Width attribute code |
| width_oe | output | 1 | Drive enable for the width attribute lines |
| dir_o | output | 1 | Write/read indicator |
| dc_o | output | 1 | Data/code indicator |

## Verification
A wrong remaining-count or current-address register shows up at the next address phase after the first piece. It appears as an unexpected `bus_addr` or lane pattern, or as a missing or extra transaction. A corrupted beat counter appears within at most four cycles, as `burst_last` on the wrong data phase. A bad phase register shows up as a hold being granted mid-burst or as lanes changing inside a transaction. The sweep covers every start offset in a 16-byte block and every byte count up to 16 on all three widths, so each split pattern and each lane encoding is compared against its arithmetic expectation.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RW_8    = 2'b00,
        RW_16   = 2'b01,
        RW_32   = 2'b10,
        RW_HALT = 2'b11
    } rwidth_e;

    // log2 of the bus word size in bytes for a region width
    function automatic logic [1:0] width_shift(rwidth_e w);
        case (w)
            RW_8:    width_shift = 2'd0;
            RW_16:   width_shift = 2'd1;
            default: width_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/bls_split_plan.sv
// Sizes the next piece of a request: byte length, beat count and the number
// of bytes that land in the first bus word.
module bls_split_plan
    import bls_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int BURST_MAX = 4,
    parameter int BLK_W     = $clog2(BURST_MAX * 4)
) (
    input  logic [BLK_W-1:0]                 addr_lo,
    input  logic [CNT_W-1:0]                 rem,
    input  rwidth_e                          width,
    output logic [CNT_W-1:0]                 len,
    output logic [$clog2(BURST_MAX+1)-1:0]   beats,
    output logic [2:0]                       first_cnt
);

    localparam int BEAT_W    = $clog2(BURST_MAX + 1);
    localparam int BLK_BYTES = 1 << BLK_W;
    localparam int CW        = ((CNT_W > BLK_W) ? CNT_W : BLK_W) + 2;

    logic [1:0]    sh;
    logic [CW-1:0] wb, off, rem_c, head, words, room, k;
    logic [CW-1:0] len_c, beats_c, cnt_c;

    always_comb begin
        sh    = width_shift(width);
        wb    = CW'(1) << sh;
        off   = CW'(addr_lo[1:0]) & (wb - CW'(1));
        rem_c = CW'(rem);
        head  = wb - off;
        words = rem_c >> sh;
        room  = (CW'(BLK_BYTES) - CW'(addr_lo)) >> sh;
        k     = words;
        if (room < k)             k = room;
        if (CW'(BURST_MAX) < k)   k = CW'(BURST_MAX);

        if (off != '0 || rem_c < wb) begin
            len_c   = (rem_c < head) ? rem_c : head;
            beats_c = CW'(1);
            cnt_c   = len_c;
        end else begin
            len_c   = k << sh;
            beats_c = k;
            cnt_c   = wb;
        end
    end

    assign len       = len_c[CNT_W-1:0];
    assign beats     = beats_c[BEAT_W-1:0];
    assign first_cnt = cnt_c[2:0];

endmodule

// File: rtl/bls_lane_enc.sv
// Maps start offset, byte count and region width onto the four lane outputs.
module bls_lane_enc
    import bls_pkg::*;
(
    input  rwidth_e          width,
    input  logic [1:0]       addr_lo,
    input  logic [2:0]       cnt,
    output logic [LANES-1:0] lane_n
);

    logic [LANES-1:0] en32;
    logic             lo16_en, hi16_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign en32[i] = (3'(i) >= {1'b0, addr_lo}) &&
                         (3'(i) <  ({1'b0, addr_lo} + cnt));
    end

    assign lo16_en = ~addr_lo[0];
    assign hi16_en = addr_lo[0] | (cnt >= 3'd2);

    always_comb begin
        case (width)
            RW_8:    lane_n = {2'b11, addr_lo[1], addr_lo[0]};
            RW_16:   lane_n = {~hi16_en, 1'b1, addr_lo[1], ~lo16_en};
            default: lane_n = ~en32;
        endcase
    end

endmodule

// File: rtl/bus_lane_seq.sv
module bus_lane_seq
    import bls_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 16,
    parameter int BURST_MAX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0] req_nbytes,
    input  logic [1:0]                 req_width,
    input  logic                       req_write,
    input  logic                       req_data,
    input  logic                       cpu_halted,
    input  logic                       hold_req,
    output logic                       hold_ack,
    output logic                       addr_phase,
    output logic                       data_phase,
    output logic                       burst_last,
    output logic [ADDR_W-1:2]          bus_addr,
    output logic [3:0]                 lane_n,
    output logic [1:0]                 width_o,
    output logic                       width_oe,
    output logic                       dir_o,
    output logic                       dc_o
);

    localparam int CNT_W  = $clog2(MAX_BYTES + 1);
    localparam int BEAT_W = $clog2(BURST_MAX + 1);
    localparam int BLK_W  = $clog2(BURST_MAX * 4);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   cur;
        logic [CNT_W-1:0]    rem;
        logic [CNT_W-1:0]    len;
        logic [BEAT_W-1:0]   beats;
        rwidth_e             width;
        logic                write;
        logic                data;
        logic [LANES-1:0]    lanes;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase: PH_IDLE, cur: '0, rem: '0, len: '0, beats: '0,
        width: RW_32, write: 1'b0, data: 1'b0, lanes: '1
    };

    seq_t st_q, st_d;

    // ---------------- piece planning ----------------
    logic [ADDR_W-1:0] adv_cur, plan_addr;
    logic [CNT_W-1:0]  adv_rem, plan_rem, plan_len;
    rwidth_e           req_w, plan_width;
    logic [BEAT_W-1:0] plan_beats;
    logic [2:0]        plan_cnt;
    logic [LANES-1:0]  plan_lanes;

    assign adv_cur = st_q.cur + ADDR_W'(st_q.len);
    assign adv_rem = st_q.rem - st_q.len;
    assign req_w   = (req_width == RW_HALT) ? RW_32 : rwidth_e'(req_width);

    always_comb begin
        case (st_q.phase)
            PH_IDLE: begin
                plan_addr  = req_addr;
                plan_rem   = req_nbytes;
                plan_width = req_w;
            end
            PH_DATA: begin
                plan_addr  = adv_cur;
                plan_rem   = adv_rem;
                plan_width = st_q.width;
            end
            default: begin
                plan_addr  = st_q.cur;
                plan_rem   = st_q.rem;
                plan_width = st_q.width;
            end
        endcase
    end

    bls_split_plan #(
        .CNT_W     (CNT_W),
        .BURST_MAX (BURST_MAX),
        .BLK_W     (BLK_W)
    ) plan_i (
        .addr_lo   (plan_addr[BLK_W-1:0]),
        .rem       (plan_rem),
        .width     (plan_width),
        .len       (plan_len),
        .beats     (plan_beats),
        .first_cnt (plan_cnt)
    );

    bls_lane_enc lane_i (
        .width   (plan_width),
        .addr_lo (plan_addr[1:0]),
        .cnt     (plan_cnt),
        .lane_n  (plan_lanes)
    );

    // ---------------- next-state ----------------
    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (hold_req) begin
                    st_d.phase = PH_HOLD;
                end else if (req_valid && req_nbytes != '0) begin
                    st_d.phase = PH_ADDR;
                    st_d.cur   = req_addr;
                    st_d.rem   = req_nbytes;
                    st_d.width = req_w;
                    st_d.write = req_write;
                    st_d.data  = req_data;
                    st_d.len   = plan_len;
                    st_d.beats = plan_beats;
                    st_d.lanes = plan_lanes;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_DATA;
            end
            PH_DATA: begin
                if (st_q.beats == BEAT_W'(1)) begin
                    st_d.cur = adv_cur;
                    st_d.rem = adv_rem;
                    if (hold_req) begin
                        st_d.phase = PH_HOLD;
                    end else if (adv_rem != '0) begin
                        st_d.phase = PH_ADDR;
                        st_d.len   = plan_len;
                        st_d.beats = plan_beats;
                        st_d.lanes = plan_lanes;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else begin
                    st_d.beats = st_q.beats - BEAT_W'(1);
                end
            end
            default: begin
                if (!hold_req) begin
                    if (st_q.rem != '0) begin
                        st_d.phase = PH_ADDR;
                        st_d.len   = plan_len;
                        st_d.beats = plan_beats;
                        st_d.lanes = plan_lanes;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RST;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    logic active;
    assign active     = (st_q.phase == PH_ADDR) || (st_q.phase == PH_DATA);
    assign addr_phase = (st_q.phase == PH_ADDR);
    assign data_phase = (st_q.phase == PH_DATA);
    assign burst_last = data_phase && (st_q.beats == BEAT_W'(1));
    assign hold_ack   = (st_q.phase == PH_HOLD);
    assign req_ready  = (st_q.phase == PH_IDLE) && !hold_req;
    assign lane_n     = active ? st_q.lanes : '1;
    assign dir_o      = active & st_q.write;
    assign dc_o       = active & st_q.data;
    assign bus_addr   = addr_phase ? st_q.cur[ADDR_W-1:2] : '0;
    assign width_oe   = !hold_ack;
    assign width_o    = (st_q.phase == PH_IDLE && cpu_halted) ? RW_HALT :
                        hold_ack ? 2'b00 : st_q.width;

    // ---------------- assertions ----------------
    p_addr_to_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> data_phase);

    p_burst_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !burst_last) |=> data_phase);

    p_attr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_phase |-> ($stable(lane_n) && $stable(dir_o) && $stable(dc_o)));

    p_beats_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> (st_q.beats != '0 && st_q.beats <= BEAT_W'(BURST_MAX)));

    p_lane16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && width_o == 2'b01) |-> lane_n[2]);

    p_lane8_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && width_o == 2'b00) |-> (lane_n[3:2] == 2'b11));

    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!width_oe && lane_n == 4'hF && !addr_phase && !data_phase));

    p_hold_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(burst_last) || !$past(addr_phase || data_phase)));

    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase || data_phase || hold_ack) |-> !req_ready);

endmodule

// File: tb/bus_lane_seq_tb_top.sv
module bus_lane_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic [4:0]  req_nbytes;
    logic [1:0]  req_width;
    logic        req_write, req_data, cpu_halted, hold_req, hold_ack;
    logic        addr_phase, data_phase, burst_last;
    logic [31:2] bus_addr;
    logic [3:0]  lane_n;
    logic [1:0]  width_o;
    logic        width_oe, dir_o, dc_o;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    bus_lane_seq dut_i (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Expected piece per the splitting and lane rules
    task automatic plan(input int unsigned cur, input int rem, input int w,
                        output int len, output int beats, output logic [3:0] lanes);
        int wb, off, k, room, cnt;
        wb  = 1 << w;
        off = int'(cur % wb);
        if (off != 0 || rem < wb) begin
            len = (rem < wb - off) ? rem : wb - off;
            beats = 1;
            cnt = len;
        end else begin
            k    = rem / wb;
            room = (16 - int'(cur % 16)) / wb;
            if (room < k) k = room;
            if (4 < k) k = 4;
            len = k * wb;
            beats = k;
            cnt = wb;
        end
        if (w == 2) begin
            for (int i = 0; i < 4; i++) lanes[i] = !(i >= off && i < off + cnt);
        end else if (w == 1) begin
            lanes = {!(off + cnt > 1), 1'b1, cur[1], !(off == 0)};
        end else begin
            lanes = {2'b11, cur[1], cur[0]};
        end
    endtask

    task automatic run_req(input int unsigned a, input int n, input int w,
                           input bit wr, input bit dc, input bit do_hold);
        int unsigned cur;
        int rem, len, beats, g;
        logic [3:0] lanes;
        string rq;
        bit hold_now;
        rq = (w == 2) ? "R2" : (w == 1) ? "R3" : "R4";
        g = 0;
        while (!req_ready && g < 50) begin @(negedge clk); g++; end
        req_addr = a; req_nbytes = 5'(n); req_width = 2'(w);
        req_write = wr; req_data = dc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) begin
            chk(!addr_phase && req_ready, "R6", "zero-length request idle", addr_phase, 0);
            return;
        end
        cur = a; rem = n; hold_now = do_hold;
        while (rem > 0) begin
            plan(cur, rem, w, len, beats, lanes);
            chk(addr_phase, "R7", "address phase expected", addr_phase, 1);
            chk(bus_addr == 30'(cur >> 2), "R8", "bus_addr", bus_addr, cur >> 2);
            chk(lane_n == lanes, rq, "lane outputs", lane_n, lanes);
            chk(width_o == 2'(w), "R5", "width code", width_o, w);
            chk(dir_o == wr && dc_o == dc, "R9", "dir/dc", {dir_o, dc_o}, {wr, dc});
            chk(!req_ready, "R11", "ready while busy", req_ready, 0);
            if (hold_now) hold_req = 1'b1;
            for (int b = 1; b <= beats; b++) begin
                @(negedge clk);
                chk(data_phase, "R7", "data phase", data_phase, 1);
                chk(burst_last == (b == beats), "R6", "burst_last position", burst_last, b == beats);
                chk(lane_n == lanes && dir_o == wr && dc_o == dc, "R8", "lanes held",
                    lane_n, lanes);
            end
            cur += len; rem -= len;
            @(negedge clk);
            if (hold_now) begin
                for (int h = 0; h < 3; h++) begin
                    chk(hold_ack && !width_oe && lane_n == 4'hF && !addr_phase, "R10",
                        "hand-over state", {hold_ack, width_oe, lane_n}, 6'b101111);
                    if (h < 2) @(negedge clk);
                end
                hold_req = 1'b0;
                hold_now = 0;
                @(negedge clk);
            end
        end
        chk(!addr_phase && !data_phase && req_ready, "R11", "idle after request",
            {addr_phase, data_phase, req_ready}, 3'b001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_nbytes = '0;
        req_width = 2'b10; req_write = 1'b0; req_data = 1'b0;
        cpu_halted = 1'b0; hold_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && lane_n == 4'hF && !hold_ack && !addr_phase && !data_phase,
            "R1", "reset outputs", {req_ready, lane_n, hold_ack}, 6'b111110);
        chk(width_oe && width_o == 2'b10, "R1", "reset width", {width_oe, width_o}, 3'b110);

        cpu_halted = 1'b1;
        #1;
        chk(width_o == 2'b11, "R5", "halted code", width_o, 3);
        @(negedge clk);
        cpu_halted = 1'b0;

        // Exhaustive sweep: every width, start offset and byte count
        for (int w = 0; w < 3; w++)
            for (int off = 0; off < 16; off++)
                for (int n = 1; n <= 16; n++)
                    run_req(32'h8765_4300 + off, n, w, 1'((n + off) & 1), 1'(off & 1), 0);

        run_req(32'h0000_0044, 0, 2, 0, 0, 0);

        // Hand-over after the first piece, on wide and narrow regions
        run_req(32'h0000_0101, 16, 2, 1, 1, 1);
        run_req(32'h0000_0203, 9, 0, 0, 1, 1);
        run_req(32'h0000_0305, 7, 1, 1, 0, 1);
        run_req(32'h0000_0400, 4, 2, 0, 0, 1);

        // Hand-over from idle, with a request presented meanwhile
        @(negedge clk);
        hold_req = 1'b1; req_valid = 1'b1; req_addr = 32'h10; req_nbytes = 5'd4;
        req_width = 2'b10;
        #1;
        chk(!req_ready, "R11", "ready under hold_req", req_ready, 0);
        @(negedge clk);
        chk(hold_ack && !width_oe, "R10", "idle hand-over", {hold_ack, width_oe}, 2'b10);
        req_valid = 1'b0; hold_req = 1'b0;
        @(negedge clk);
        chk(!addr_phase && !hold_ack && req_ready, "R11", "request during hand-over ignored",
            {addr_phase, hold_ack, req_ready}, 3'b001);
        @(negedge clk);
        chk(!addr_phase, "R11", "still no transaction", addr_phase, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule